// File: doc/BRIEF.md
# Prescaled Dual Down-Counting Timer

This block holds two down-counters of `CNT_W` bits that share one programmable prescaler of `PRE_W` bits. Software programs it through a small register port with APB-style signals. The prescaler counts down from its reload value and emits a tick each time it passes zero. Every enabled counter decrements on each tick. A freshly started counter therefore expires after (prescaler reload + 1) x (counter value + 1) clock cycles.

When a counter underflows, it takes its reload value again. It then either keeps running or stops, as its control word selects. If its interrupt enable is set, it pulses its own line of the interrupt vector for one cycle. Timer `i` drives line `IRQ_BASE + i`.

Writes to the counter or to the prescaler always win over an event that falls in the same cycle, so software can restart timing at any moment.

Top module: `dual_ptimer`

## Requirements
- R1: After reset every register reads 0 and no interrupt line is high.
- R2: The prescaler current value is at offset 0x300 and its reload value at 0x304, and writes keep only the low 16 bits. A write to 0x304 sets both the reload value and the current value. A write to 0x300 sets only the current value. In every other cycle the current value decrements, and it takes the reload value in the cycle after it reads 0.
- R3: An enabled timer decrements once per prescaler tick, where a tick is a cycle in which the prescaler current value is 0. After the prescaler is set to S and the timer's counter is C, the first underflow falls in cycle (S+1)(C+1).
- R4: On underflow the counter is loaded from its reload register. With automatic reload, the next underflow follows (S+1)(R+1) cycles later.
- R5: An underflow pulses interrupt line IRQ_BASE+i (bit 8 for timer 0 and bit 9 for timer 1 by default) for exactly the underflow cycle, and only while control bit 3 is 1.
- R6: With control bit 0 clear, the counter holds its value and reads return that held value.
- R7: With control bit 1 clear, the timer clears its own bit 0 at underflow and stops. Control then reads back with bit 0 at 0.
- R8: Writing control bit 2 as 1 loads the counter from the reload register at once, and bit 2 always reads 0.
- R9: A write to a counter register in the cycle in which that counter would underflow cancels the underflow and its pulse, and counting restarts from the written value.
- R10: A write to 0x300 or 0x304 in a cycle in which the prescaler reads 0 suppresses that tick, so no counter moves.
- R11: Timer i has its counter at 0x310+0x10*i, its reload at 0x314+0x10*i and its control at 0x318+0x10*i. Control bits 0, 1 and 3 are run, auto-reload and interrupt enable. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational from paddr while psel is high |
| irq_lines | output | NLINES | Interrupt pulses, timer i on bit IRQ_BASE+i |

## Verification
Two collisions matter. A counter write can land in the very cycle in which that counter would underflow. A prescaler write can land in the cycle in which the prescaler would wrap and tick. The bench steers a behavioural model to the cycle just before each event and then issues the write in the event cycle. It checks that no interrupt pulse appears, that the counter restarts from the written value, and, for the prescaler case, that a counter read before the collision equals a read after it.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;

  localparam logic [11:0] SCL_VAL_OFS = 12'h300;
  localparam logic [11:0] SCL_RLD_OFS = 12'h304;
  localparam logic [11:0] TMR_FIRST   = 12'h310;
  localparam logic [11:0] TMR_STRIDE  = 12'h010;
  localparam logic [11:0] CNT_OFS     = 12'h000;
  localparam logic [11:0] RLD_OFS     = 12'h004;
  localparam logic [11:0] CTL_OFS     = 12'h008;

  localparam int CB_RUN  = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_LOAD = 2;
  localparam int CB_IE   = 3;

  typedef struct packed {
    logic irq_en;
    logic auto_rld;
    logic run;
  } tctl_t;

  function automatic logic [11:0] tmr_addr(input int idx, input logic [11:0] ofs);
    return TMR_FIRST + TMR_STRIDE * idx[11:0] + ofs;
  endfunction

  function automatic logic [31:0] ctl_to_word(input tctl_t c);
    logic [31:0] w;
    w = '0;
    w[CB_RUN]  = c.run;
    w[CB_AUTO] = c.auto_rld;
    w[CB_IE]   = c.irq_en;
    return w;
  endfunction

  function automatic tctl_t ctl_from_bits(input logic [3:0] b);
    tctl_t c;
    c.run      = b[CB_RUN];
    c.auto_rld = b[CB_AUTO];
    c.irq_en   = b[CB_IE];
    return c;
  endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
`timescale 1ns/1ps
module ptimer_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val_i,
  input  logic             wr_rld_i,
  input  logic [PRE_W-1:0] wdata_i,
  output logic [PRE_W-1:0] cnt_o,
  output logic [PRE_W-1:0] rld_o,
  output logic             tick_o
);

  logic [PRE_W-1:0] cnt_q, rld_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = at_zero && !wr_val_i && !wr_rld_i;
  assign cnt_o   = cnt_q;
  assign rld_o   = rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (wr_rld_i) begin
      rld_q <= wdata_i;
      cnt_q <= wdata_i;
    end else if (wr_val_i) begin
      cnt_q <= wdata_i;
    end else if (at_zero) begin
      cnt_q <= rld_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: wrap to the reload value after a tick
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == $past(rld_q));

  // R2: plain countdown when not written
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !wr_val_i && !wr_rld_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R10: a value write restarts the prescaler from the written value
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val_i && !wr_rld_i) |=> cnt_q == $past(wdata_i));

endmodule

// File: rtl/ptimer_channel.sv
`timescale 1ns/1ps
module ptimer_channel
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_rld_i,
  input  logic             wr_ctl_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output tctl_t            ctl_o,
  output logic             uflow_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, rld_q;
  tctl_t            ctl_q;
  logic             load_now;
  logic             step_en;

  assign load_now = wr_ctl_i && wdata_i[CB_LOAD];
  assign step_en  = ctl_q.run && tick_i;
  assign uflow_o  = step_en && (cnt_q == '0) && !wr_cnt_i;
  assign irq_o    = uflow_o && ctl_q.irq_en;
  assign cnt_o    = cnt_q;
  assign rld_o    = rld_q;
  assign ctl_o    = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (load_now || uflow_o) begin
      cnt_q <= rld_q;
    end else if (step_en) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
    end else if (wr_rld_i) begin
      rld_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl_i) begin
      ctl_q <= ctl_from_bits(wdata_i[3:0]);
    end else if (uflow_o && !ctl_q.auto_rld) begin
      ctl_q.run <= 1'b0;
    end
  end

  // R4: underflow reloads the counter
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |=> cnt_q == $past(rld_q));

  // R6: a stopped counter keeps its value
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !wr_cnt_i && !load_now) |=> $stable(cnt_q));

  // R7: one-shot mode stops itself
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_o && !ctl_q.auto_rld && !wr_ctl_i) |=> !ctl_q.run);

  // R8: immediate load takes the reload value
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !wr_cnt_i) |=> cnt_q == $past(rld_q));

  // R9: a counter write restarts from the written value
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> cnt_q == $past(wdata_i));

endmodule

// File: rtl/dual_ptimer.sv
`timescale 1ns/1ps
module dual_ptimer
  import ptimer_pkg::*;
#(
  parameter int NTIMERS  = 2,
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int IRQ_BASE = 8,
  parameter int NLINES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [NLINES-1:0] irq_lines
);

  localparam int LAST_LINE = IRQ_BASE + NTIMERS - 1;

  logic [11:0]      ofs;
  logic             wr_stb;
  logic             pre_tick;
  logic [PRE_W-1:0] pre_cnt, pre_rld;

  logic [CNT_W-1:0] cnt_v [NTIMERS];
  logic [CNT_W-1:0] rld_v [NTIMERS];
  tctl_t            ctl_v [NTIMERS];
  logic [NTIMERS-1:0] uflow_v, irq_v;

  assign ofs    = paddr[11:0];
  assign wr_stb = psel && penable && pwrite;

  ptimer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_val_i (wr_stb && ofs == SCL_VAL_OFS),
    .wr_rld_i (wr_stb && ofs == SCL_RLD_OFS),
    .wdata_i  (pwdata[PRE_W-1:0]),
    .cnt_o    (pre_cnt),
    .rld_o    (pre_rld),
    .tick_o   (pre_tick)
  );

  for (genvar g = 0; g < NTIMERS; g++) begin : g_tmr
    ptimer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (pre_tick),
      .wr_cnt_i (wr_stb && ofs == tmr_addr(g, CNT_OFS)),
      .wr_rld_i (wr_stb && ofs == tmr_addr(g, RLD_OFS)),
      .wr_ctl_i (wr_stb && ofs == tmr_addr(g, CTL_OFS)),
      .wdata_i  (pwdata[CNT_W-1:0]),
      .cnt_o    (cnt_v[g]),
      .rld_o    (rld_v[g]),
      .ctl_o    (ctl_v[g]),
      .uflow_o  (uflow_v[g]),
      .irq_o    (irq_v[g])
    );
  end

  always_comb begin
    irq_lines = '0;
    for (int i = 0; i < NTIMERS; i++) begin
      irq_lines[IRQ_BASE + i] = irq_v[i];
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (ofs == SCL_VAL_OFS) prdata = DATA_W'(pre_cnt);
      if (ofs == SCL_RLD_OFS) prdata = DATA_W'(pre_rld);
      for (int i = 0; i < NTIMERS; i++) begin
        if (ofs == tmr_addr(i, CNT_OFS)) prdata = DATA_W'(cnt_v[i]);
        if (ofs == tmr_addr(i, RLD_OFS)) prdata = DATA_W'(rld_v[i]);
        if (ofs == tmr_addr(i, CTL_OFS)) prdata = DATA_W'(ctl_to_word(ctl_v[i]));
      end
    end
  end

  // R5: a pulse only appears on lines owned by a timer that underflowed
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines[LAST_LINE] |-> uflow_v[NTIMERS-1]));

  // R3: no timer underflows outside a prescaler tick
  p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_v != '0) |-> pre_tick);

endmodule

// File: tb/sim_dual_ptimer.sv
`timescale 1ns/1ps
module sim_dual_ptimer;

  localparam int IB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [15:0] irq_lines;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] last_irq;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  dual_ptimer u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_lines(irq_lines)
  );

  // behavioural reference state
  longint pre, prl;
  longint cnt [2];
  longint rld [2];
  bit     en [2], ar [2], ie [2];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_tick(input bit w, input logic [11:0] a);
    return pre == 0 && !(w && (a == 12'h300 || a == 12'h304));
  endfunction

  function automatic bit m_uf(input int i, input bit w, input logic [11:0] a);
    return en[i] && m_tick(w, a) && cnt[i] == 0 && !(w && a == 12'h310 + 12'(16 * i));
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 12'h300) r = 32'(pre);
    if (a == 12'h304) r = 32'(prl);
    for (int i = 0; i < 2; i++) begin
      if (a == 12'h310 + 12'(16 * i)) r = 32'(cnt[i]);
      if (a == 12'h314 + 12'(16 * i)) r = 32'(rld[i]);
      if (a == 12'h318 + 12'(16 * i)) r = {28'd0, ie[i], 1'b0, ar[i], en[i]};
    end
    return r;
  endfunction

  task automatic m_update(input bit w, input logic [11:0] a, input logic [31:0] d);
    bit tk;
    bit uf [2];
    tk = m_tick(w, a);
    for (int i = 0; i < 2; i++) uf[i] = m_uf(i, w, a);
    if (w && a == 12'h304) begin prl = d & 32'hFFFF; pre = prl; end
    else if (w && a == 12'h300) pre = d & 32'hFFFF;
    else if (pre == 0) pre = prl;
    else pre = pre - 1;
    for (int i = 0; i < 2; i++) begin
      logic [11:0] b;
      b = 12'h310 + 12'(16 * i);
      if (w && a == b) cnt[i] = d;
      else if (w && a == b + 12'h8 && d[2]) cnt[i] = rld[i];
      else if (uf[i]) cnt[i] = rld[i];
      else if (en[i] && tk) cnt[i] = cnt[i] - 1;
      if (w && a == b + 12'h4) rld[i] = d;
      if (w && a == b + 12'h8) begin en[i] = d[0]; ar[i] = d[1]; ie[i] = d[3]; end
      else if (uf[i] && !ar[i]) en[i] = 1'b0;
    end
  endtask

  // one bus cycle; entered and left just after a falling edge
  task automatic step(input bit w, input logic [11:0] a, input logic [31:0] d,
                      input bit rd, input string tag);
    logic [15:0] exp_irq;
    psel = w | rd; penable = w | rd; pwrite = w; paddr = a; pwdata = d;
    #1;
    exp_irq = '0;
    for (int i = 0; i < 2; i++) exp_irq[IB + i] = m_uf(i, w, a) && ie[i];
    check("R5 irq", {16'd0, irq_lines}, {16'd0, exp_irq});
    last_irq = irq_lines;
    if (rd) begin
      last_rd = prdata;
      check(tag, prdata, m_read(a));
    end
    @(posedge clk);
    m_update(w, a, d);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, "R11 write");
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b0, a, 32'd0, 1'b1, tag);
  endtask

  task automatic idle();
    step(1'b0, 12'd0, 32'd0, 1'b0, "R5 idle");
  endtask

  initial begin
    pre = 0; prl = 0;
    for (int i = 0; i < 2; i++) begin cnt[i] = 0; rld[i] = 0; en[i] = 0; ar[i] = 0; ie[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(12'h300, "R1"); check("R1 scaler", last_rd, 32'd0);
    rd(12'h304, "R1"); check("R1 scaler reload", last_rd, 32'd0);
    rd(12'h310, "R1"); check("R1 counter", last_rd, 32'd0);
    rd(12'h318, "R1"); check("R1 control", last_rd, 32'd0);
    rd(12'h328, "R1"); check("R1 control2", last_rd, 32'd0);

    // R11: unmapped offsets
    rd(12'h308, "R11"); check("R11 hole", last_rd, 32'd0);
    rd(12'h31C, "R11"); check("R11 hole", last_rd, 32'd0);
    rd(12'h000, "R11"); check("R11 hole", last_rd, 32'd0);

    // R2: 16-bit truncation and value write
    wr(12'h304, 32'h0001_2345);
    rd(12'h304, "R2"); check("R2 reload trunc", last_rd, 32'h2345);
    wr(12'h300, 32'h000A_BCDE);
    rd(12'h300, "R2"); check("R2 value trunc", last_rd, 32'hBCDE);
    for (int k = 0; k < 4; k++) rd(12'h300, "R2");

    // R3 R4 R5: first expiry after (S+1)(C+1), then (S+1)(R+1)
    wr(12'h310, 32'd2);
    wr(12'h314, 32'd5);
    wr(12'h304, 32'd3);
    begin
      int k;
      int got;
      got = 0;
      wr(12'h318, 32'hB);
      for (k = 2; k <= 40; k++) begin
        idle();
        if (last_irq[IB] && got == 0) got = k;
      end
      check("R3 first expiry cycle", 32'(got), 32'd12);
    end
    begin
      int got;
      got = 0;
      for (int k = 1; k <= 60 && got == 0; k++) begin
        idle();
        if (last_irq[IB]) got = k;
      end
      // earlier loop ran 40 cycles: first pulse at 12, next at 36, so 60-36+...
      check("R4 reload period", 32'(got), 32'd20);
    end
    rd(12'h310, "R4");

    // R6: disabled timer holds
    wr(12'h318, 32'h0);
    begin
      logic [31:0] v1;
      rd(12'h310, "R6"); v1 = last_rd;
      repeat (9) idle();
      rd(12'h310, "R6"); check("R6 hold", last_rd, v1);
    end

    // R7: one-shot on timer 1
    wr(12'h324, 32'd7);
    wr(12'h320, 32'd1);
    wr(12'h328, 32'h9);
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 40 && !seen; k++) begin
        idle();
        if (last_irq[IB + 1]) seen = 1'b1;
      end
      check("R7 pulse seen", 32'(seen), 32'd1);
    end
    rd(12'h328, "R7"); check("R7 run cleared", last_rd, 32'h8);
    rd(12'h320, "R4"); check("R4 one-shot reload", last_rd, 32'd7);
    begin
      bit seen;
      seen = 1'b0;
      repeat (40) begin idle(); if (last_irq[IB + 1]) seen = 1'b1; end
      check("R7 stays stopped", 32'(seen), 32'd0);
    end

    // R8: immediate load, bit reads 0
    wr(12'h324, 32'd9);
    wr(12'h328, 32'h4);
    rd(12'h320, "R8"); check("R8 loaded", last_rd, 32'd9);
    rd(12'h328, "R8"); check("R8 bit2 reads 0", last_rd, 32'd0);

    // R9: counter write collides with underflow
    wr(12'h318, 32'hB);
    wr(12'h304, 32'd0);
    wr(12'h310, 32'd0);
    wr(12'h310, 32'd4);
    check("R9 pulse cancelled", {16'd0, last_irq}, 32'd0);
    rd(12'h310, "R9"); check("R9 restart value", last_rd, 32'd4);
    repeat (12) idle();

    // R10: scaler write collides with a tick
    wr(12'h304, 32'd2);
    begin
      logic [31:0] v;
      for (int k = 0; k < 10 && pre != 1; k++) idle();
      rd(12'h310, "R10"); v = last_rd;
      wr(12'h300, 32'd2);
      rd(12'h310, "R10"); check("R10 tick suppressed", last_rd, v);
    end
    repeat (20) idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule